// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block turns an idle-high serial line into bytes. A free-running oversampling tick, sixteen per bit period, paces it. A falling edge on the line starts a candidate frame. That frame is kept only if the line is still low at the middle of the start bit. The receiver then samples each following bit once per sixteen ticks at its centre. Eight data bits arrive least significant first. An optional parity bit follows them, with even or odd sense, and then a single stop bit that must be high.

Each finished character goes to a holding register that the CPU reads. A full flag marks a clean character that is waiting to be read. Three sticky error flags record overrun, parity mismatch and a bad stop bit. When the holding register is still full, an overrun leaves the old byte in place. A parity or stop-bit error still stores the new byte, so software can inspect it. A receive interrupt and an error interrupt, both gated by a common enable, signal software. Software acknowledges a read with a strobe and clears each error with its own strobe. Back-to-back frames are received without loss if every byte is acknowledged before the next one completes.

Top module: `serial_rx_flags`

## Requirements
- R1: A low level on the line starts a frame only if the line is still low 8 ticks after the low was first seen. A shorter low pulse leaves every output unchanged, and the receiver goes back to looking for a start.
- R2: An error-free frame delivers its eight data bits to `rx_data`, with the first bit received in bit 0, and sets `rx_full` to 1.
- R3: When `par_en` is 1, a parity bit follows bit 7. With `par_odd` at 0 the data bits plus the parity bit must hold an even number of ones; with `par_odd` at 1, an odd number. When `par_en` is 0, the stop bit directly follows bit 7 and `par_err` never sets.
- R4: A parity mismatch sets `par_err` and writes the byte to `rx_data`, and `rx_full` stays 0.
- R5: A stop bit sampled at 0 sets `frm_err` and writes the byte to `rx_data`. After it, no new frame begins until the line has returned to 1, so a line held low yields one frame only.
- R6: A frame that completes while `rx_full` is 1 sets `ovr_err`. `rx_data` keeps the earlier byte and `rx_full` stays 1.
- R7: A one-cycle pulse on `rd_ack` clears `rx_full`.
- R8: Each error flag stays set until its own clear strobe (`clr_ovr`, `clr_perr`, `clr_ferr`) is pulsed, whatever frames follow. A new error in the same cycle as the clear wins.
- R9: `irq_rx` equals `irq_en` AND `rx_full`. `irq_err` equals `irq_en` AND the OR of the three error flags.
- R10: The receiver advances only on cycles with `tick_16x` high. Without ticks, line activity has no effect, and any tick spacing gives the same result as a tick on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| irq_en | input | 1 | Interrupt enable for both interrupt outputs |
| rd_ack | input | 1 | Strobe: byte read, clear full flag |
| clr_ovr | input | 1 | Strobe: clear overrun flag |
| clr_perr | input | 1 | Strobe: clear parity-error flag |
| clr_ferr | input | 1 | Strobe: clear framing-error flag |
| rx_data | output | 8 | Holding register |
| rx_full | output | 1 | Clean byte waiting |
| ovr_err | output | 1 | Overrun flag |
| par_err | output | 1 | Parity-error flag |
| frm_err | output | 1 | Framing-error flag |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The hardest states to reach from the ports are the two that need the line held in an unusual shape over time. One is a low level that outlasts the stop bit. The other is a second frame that arrives while the first byte is still unread. The stimulus drives a frame with a low stop bit and keeps the line low for three more bit times. It expects exactly one stored byte from this. It then sends two frames without an acknowledge and expects the first byte to survive. A short low glitch, a stretch with the tick held off, and a slower tick spacing show that frame detection depends on the mid-bit check and on the tick alone.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_char_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b1;
          else        stage_q[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b1;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     line,
  input  logic     par_en,
  input  logic     par_odd,
  output logic     done,
  output rx_char_t chr
);
  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned BW = $clog2(CHAR_W);
  localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(CHAR_W - 1);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              pbad_q, pbad_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    pbad_d  = pbad_q;
    done    = 1'b0;
    if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!line) begin
            state_d = ST_START;
            cnt_d   = '0;
          end
        end
        ST_START: begin
          if (cnt_q == MID_CNT) begin
            cnt_d   = '0;
            bit_d   = '0;
            state_d = line ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_DATA: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d = '0;
            sh_d  = {line, sh_q[CHAR_W-1:1]};
            if (bit_q == LAST_BIT) state_d = par_en ? ST_PAR : ST_STOP;
            else                   bit_d   = bit_q + BW'(1);
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_PAR: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d   = '0;
            pbad_d  = (^sh_q) ^ line ^ par_odd;
            state_d = ST_STOP;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_STOP: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d   = '0;
            done    = 1'b1;
            state_d = line ? ST_IDLE : ST_WAITHI;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_WAITHI: begin
          if (line) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      pbad_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      pbad_q  <= pbad_d;
    end
  end

  assign chr.data = sh_q;
  assign chr.perr = par_en & pbad_q;
  assign chr.ferr = ~line;

  // R1: a start that is high again at mid-bit is dropped
  p_start_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick && cnt_q == MID_CNT && line) |=> state_q == ST_IDLE);

  // R5: a low line keeps the receiver parked after a bad stop bit
  p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAITHI && !line) |=> state_q == ST_WAITHI);

  // R5: a completion with a low line goes to the wait state
  p_ferr_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !line) |=> state_q == ST_WAITHI);

  // R10: nothing advances without a tick
  p_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(state_q) && $stable(cnt_q) && $stable(sh_q)));
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  rx_char_t          chr,
  input  logic              irq_en,
  input  logic              rd_ack,
  input  logic              clr_ovr,
  input  logic              clr_perr,
  input  logic              clr_ferr,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_full,
  output logic              ovr_err,
  output logic              par_err,
  output logic              frm_err,
  output logic              irq_rx,
  output logic              irq_err
);
  logic [CHAR_W-1:0] data_q, data_d;
  logic full_q, full_d, ovr_q, ovr_d, perr_q, perr_d, ferr_q, ferr_d;
  logic still_full;

  always_comb begin
    still_full = full_q & ~rd_ack;
    data_d = data_q;
    full_d = still_full;
    ovr_d  = ovr_q  & ~clr_ovr;
    perr_d = perr_q & ~clr_perr;
    ferr_d = ferr_q & ~clr_ferr;
    if (done) begin
      if (still_full) begin
        ovr_d = 1'b1;
      end else begin
        data_d = chr.data;
        if (chr.perr) perr_d = 1'b1;
        if (chr.ferr) ferr_d = 1'b1;
        if (!chr.perr && !chr.ferr) full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
    end
  end

  assign rx_data = data_q;
  assign rx_full = full_q;
  assign ovr_err = ovr_q;
  assign par_err = perr_q;
  assign frm_err = ferr_q;
  assign irq_rx  = irq_en & full_q;
  assign irq_err = irq_en & (ovr_q | perr_q | ferr_q);

  // R6: an overrun leaves the stored byte and the full flag alone
  p_ovr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full_q && !rd_ack) |=> (rx_full && ovr_err && $stable(rx_data)));

  // R4: a parity failure flags the byte without marking it full
  p_perr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(full_q && !rd_ack) && chr.perr) |=> (par_err && !rx_full));

  // R8: error flags are sticky without their clear strobe
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_q && !clr_perr) |=> par_err);

  // R7: acknowledge with no completion empties the register
  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !done) |=> !rx_full);
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16x,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              irq_en,
  input  logic              rd_ack,
  input  logic              clr_ovr,
  input  logic              clr_perr,
  input  logic              clr_ferr,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_full,
  output logic              ovr_err,
  output logic              par_err,
  output logic              frm_err,
  output logic              irq_rx,
  output logic              irq_err
);
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       line_s;
  logic       done;
  rx_char_t   chr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .din  (rxd),
    .dout (line_s)
  );

  serial_rx_frame #(.OSR(OSR)) u_frame (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .tick   (tick_16x),
    .line   (line_s),
    .par_en (par_en),
    .par_odd(par_odd),
    .done   (done),
    .chr    (chr)
  );

  serial_rx_status u_status (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .done    (done),
    .chr     (chr),
    .irq_en  (irq_en),
    .rd_ack  (rd_ack),
    .clr_ovr (clr_ovr),
    .clr_perr(clr_perr),
    .clr_ferr(clr_ferr),
    .rx_data (rx_data),
    .rx_full (rx_full),
    .ovr_err (ovr_err),
    .par_err (par_err),
    .frm_err (frm_err),
    .irq_rx  (irq_rx),
    .irq_err (irq_err)
  );
endmodule

// File: tb/tb_serial_rx_flags.sv
module tb_serial_rx_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rxd = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, irq_en = 1'b0;
  logic rd_ack = 1'b0, clr_ovr = 1'b0, clr_perr = 1'b0, clr_ferr = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, ovr_err, par_err, frm_err, irq_rx, irq_err;

  int n_checks = 0;
  int n_fail = 0;
  int tick_div = 1;
  int tcnt = 0;
  bit tick_off = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serial_rx_flags dut (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .irq_en(irq_en),
    .rd_ack(rd_ack), .clr_ovr(clr_ovr), .clr_perr(clr_perr), .clr_ferr(clr_ferr),
    .rx_data(rx_data), .rx_full(rx_full), .ovr_err(ovr_err),
    .par_err(par_err), .frm_err(frm_err), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // oversampling tick generator
  always @(negedge clk) begin
    if (tcnt >= tick_div - 1) tcnt = 0;
    else tcnt = tcnt + 1;
    tick <= (tcnt == 0) && !tick_off;
  end

  // behavioural reference: 2-cycle input delay, 16 ticks per bit, centre sampling
  bit m_d1 = 1, m_d2 = 1;
  int m_phase = 0;   // 0 idle,1 start,2 data,3 parity,4 stop,5 wait-for-high
  int m_ticks = 0, m_nbits = 0;
  logic [7:0] m_byte = 0;
  bit m_pfail = 0;
  logic [7:0] m_data = 0;
  bit m_full = 0, m_ovr = 0, m_perr = 0, m_ferr = 0;
  bit m_live = 0;

  always @(posedge clk) begin
    bit ln, fin, keep;
    if (!rst_n) begin
      m_d1 = 1; m_d2 = 1; m_phase = 0; m_ticks = 0; m_nbits = 0; m_byte = 0;
      m_pfail = 0; m_data = 0; m_full = 0; m_ovr = 0; m_perr = 0; m_ferr = 0;
    end else begin
      ln = m_d2;
      fin = 0;
      if (tick) begin
        if (m_phase == 0) begin
          if (!ln) begin m_phase = 1; m_ticks = 0; end
        end else if (m_phase == 5) begin
          if (ln) m_phase = 0;
        end else begin
          m_ticks++;
          if (m_phase == 1 && m_ticks == 8) begin
            m_ticks = 0; m_nbits = 0;
            m_phase = ln ? 0 : 2;
          end else if (m_ticks == 16) begin
            m_ticks = 0;
            if (m_phase == 2) begin
              m_byte = {ln, m_byte[7:1]};
              m_nbits++;
              if (m_nbits == 8) m_phase = par_en ? 3 : 4;
            end else if (m_phase == 3) begin
              m_pfail = ($countones(m_byte) + int'(ln)) % 2 != int'(par_odd);
              m_phase = 4;
            end else begin
              fin = 1;
              m_phase = ln ? 0 : 5;
            end
          end
        end
      end
      keep = m_full && !rd_ack;
      m_full = keep;
      if (clr_ovr) m_ovr = 0;
      if (clr_perr) m_perr = 0;
      if (clr_ferr) m_ferr = 0;
      if (fin) begin
        if (keep) m_ovr = 1;
        else begin
          m_data = m_byte;
          if (par_en && m_pfail) m_perr = 1;
          if (!ln) m_ferr = 1;
          if (!(par_en && m_pfail) && ln) m_full = 1;
        end
      end
      m_d2 = m_d1;
      m_d1 = rxd;
    end
  end

  always @(negedge clk) begin
    if (m_live && !finished) begin
      chk("R2 model rx_data", rx_data, m_data);
      chk("R7 model rx_full", rx_full, m_full);
      chk("R6 model ovr_err", ovr_err, m_ovr);
      chk("R4 model par_err", par_err, m_perr);
      chk("R5 model frm_err", frm_err, m_ferr);
      chk("R9 model irq_rx", irq_rx, irq_en && m_full);
      chk("R9 model irq_err", irq_err, irq_en && (m_ovr || m_perr || m_ferr));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit use_par, input bit flip_par,
                      input bit stop_v, input int extra_low);
    int per;
    bit pb;
    per = 16 * tick_div;
    pb = (^d) ^ par_odd ^ flip_par;
    rxd = 1'b0; idle(per);
    for (int b = 0; b < 8; b++) begin rxd = d[b]; idle(per); end
    if (use_par) begin rxd = pb; idle(per); end
    rxd = stop_v; idle(per);
    if (extra_low > 0) begin rxd = 1'b0; idle(extra_low * per); end
    rxd = 1'b1; idle(2 * per);
  endtask

  task automatic pulse_ack();
    rd_ack = 1'b1; idle(1); rd_ack = 1'b0; idle(1);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual running expected done");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    // reset state, R9 interrupts low
    chk("R2 reset rx_data", rx_data, 8'h00);
    chk("R7 reset rx_full", rx_full, 0);
    chk("R8 reset flags", {ovr_err, par_err, frm_err}, 3'b000);
    chk("R9 reset irqs", {irq_rx, irq_err}, 2'b00);
    rst_n = 1'b1;
    idle(6);
    m_live = 1'b1;
    irq_en = 1'b1;

    // R2: clean frame, no parity
    send(8'hA5, 0, 0, 1, 0);
    chk("R2 data A5", rx_data, 8'hA5);
    chk("R2 full", rx_full, 1);
    chk("R9 irq_rx on", irq_rx, 1);
    chk("R9 irq_err off", irq_err, 0);
    pulse_ack();
    chk("R7 ack clears full", rx_full, 0);

    // R3: even then odd parity, correct parity bit
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h3C, 1, 0, 1, 0);
    chk("R3 even data", rx_data, 8'h3C);
    chk("R3 even no perr", {rx_full, par_err}, 2'b10);
    pulse_ack();
    par_odd = 1'b1;
    send(8'h07, 1, 0, 1, 0);
    chk("R3 odd data", rx_data, 8'h07);
    chk("R3 odd no perr", {rx_full, par_err}, 2'b10);
    pulse_ack();

    // R4: wrong parity bit
    par_odd = 1'b0;
    send(8'h81, 1, 1, 1, 0);
    chk("R4 data loaded", rx_data, 8'h81);
    chk("R4 perr set", par_err, 1);
    chk("R4 full stays 0", rx_full, 0);
    chk("R9 irq_err on", irq_err, 1);

    // R8: flag survives a good frame, then clears by strobe
    par_en = 1'b0;
    send(8'h11, 0, 0, 1, 0);
    chk("R8 perr sticky", par_err, 1);
    chk("R2 data 11", rx_data, 8'h11);
    clr_perr = 1'b1; idle(1); clr_perr = 1'b0; idle(1);
    chk("R8 perr cleared", par_err, 0);
    pulse_ack();

    // R5: low stop bit, line held low three more bit times
    send(8'h5A, 0, 0, 0, 3);
    chk("R5 data loaded", rx_data, 8'h5A);
    chk("R5 ferr set", frm_err, 1);
    chk("R5 single frame no full", rx_full, 0);
    clr_ferr = 1'b1; idle(1); clr_ferr = 1'b0; idle(1);
    chk("R8 ferr cleared", frm_err, 0);

    // R1: short low glitch
    rxd = 1'b0; idle(4); rxd = 1'b1; idle(60);
    chk("R1 glitch no full", rx_full, 0);
    chk("R1 glitch data kept", rx_data, 8'h5A);
    chk("R1 glitch no flags", {ovr_err, par_err, frm_err}, 3'b000);

    // R6: second frame while unread
    send(8'h12, 0, 0, 1, 0);
    send(8'h34, 0, 0, 1, 0);
    chk("R6 old data kept", rx_data, 8'h12);
    chk("R6 full stays", rx_full, 1);
    chk("R6 ovr set", ovr_err, 1);
    clr_ovr = 1'b1; idle(1); clr_ovr = 1'b0; idle(1);
    chk("R8 ovr cleared", ovr_err, 0);
    pulse_ack();

    // R9: enable off masks both interrupts
    irq_en = 1'b0;
    send(8'h66, 0, 0, 1, 0);
    chk("R9 masked irq_rx", irq_rx, 0);
    chk("R2 data 66", {rx_full, rx_data}, 9'h166);
    pulse_ack();
    irq_en = 1'b1;

    // R10: no ticks, line activity ignored
    tick_off = 1'b1;
    rxd = 1'b0; idle(300); rxd = 1'b1; idle(10);
    tick_off = 1'b0;
    idle(100);
    chk("R10 no tick no frame", {rx_full, frm_err, rx_data}, 10'h066);

    // R10: sparser tick spacing
    tick_div = 3;
    idle(10);
    send(8'hC3, 0, 0, 1, 0);
    chk("R10 slow tick data", rx_data, 8'hC3);
    chk("R10 slow tick full", rx_full, 1);
    pulse_ack();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule